// File: doc/BRIEF.md
# Endpoint Stall and Handshake Selector

This block keeps one stall flag for each of the four endpoints of a USB function controller. For every token the packet engine reports, it picks the handshake to return: STALL, ACK or NAK. Software reaches two byte-wide registers through a simple write-enable / write-data / read-data port, and a one-bit select chooses between them. One register holds the stall flags. The other holds a single transceiver-select bit.

Endpoint 0 has special treatment so that control transfers can recover. Its flag clears itself when the packet engine signals that a setup command has been received and decoded. While the setup-pending flag is raised, software cannot set that flag. The transceiver-select bit drives an enable for an external transceiver, which replaces the internal one.

Top module: `ep_halt_ctrl`

## Requirements
- R1: With `reg_sel`=0, a write stores `reg_wdata[3:0]` as the stall flags, where bit n belongs to endpoint n. A read with `reg_sel`=0 returns the flags in bits 3:0.
- R2: Bits 7:4 of the stall register always read 0, and writing 1 to them changes nothing.
- R3: When a token addresses an endpoint whose stall flag is 1, the handshake is STALL, code 2'b11, whatever that endpoint's ready input is.
- R4: A `setup_rcvd` pulse clears the endpoint 0 flag on the next edge. If a software write of 1 to that bit lands in the same cycle, the clear wins.
- R5: While `setup_pend` is 1, a write of 1 to bit 0 leaves the endpoint 0 flag unchanged. A write of 0 to bit 0 still clears it.
- R6: A `setup_rcvd` pulse leaves the flags of endpoints 1 to 3 unchanged. Only a software write changes them.
- R7: A token to an endpoint that is not stalled gets ACK (2'b01) if `ep_ready[n]` is 1, and NAK (2'b10) if it is 0. `hs_valid` is a one-cycle pulse on the edge after `tok_valid`. `hs_code` is 2'b00 when `hs_valid` is 0. The decision uses the flags as they stood before any write in the token's cycle.
- R8: A token with `tok_ep` greater than 3 produces no handshake: `hs_valid` stays 0.
- R9: With `reg_sel`=1, a write stores `reg_wdata[0]` as the transceiver-select bit. That bit drives `ext_xcvr_en`, and it reads back in bit 0 with bits 7:1 at 0.
- R10: After reset, all stall flags are 0, the transceiver-select bit is 0 and `hs_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | 0 selects the stall register, 1 selects the transceiver register |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| setup_rcvd | input | 1 | Pulse: a setup command was received and decoded |
| setup_pend | input | 1 | Setup-pending flag |
| tok_valid | input | 1 | Token strobe |
| tok_ep | input | 4 | Endpoint number of the token |
| ep_ready | input | 4 | Per-endpoint ready for the transfer |
| hs_valid | output | 1 | Handshake strobe |
| hs_code | output | 2 | 00 none, 01 ACK, 10 NAK, 11 STALL |
| ext_xcvr_en | output | 1 | Selects the external transceiver |

## Verification
Two actions can hit the endpoint 0 flag in the same cycle: the automatic clear on a received setup command, and a software write of 1. The vector table applies a `setup_rcvd` pulse together with a write of 0x01, and the following readback must show the flag at 0. Another pair of vectors lands a token in the same cycle as a stall write, and the handshake must reflect the flags as they stood before that write.

// File: rtl/ep_halt_pkg.sv
package ep_halt_pkg;
    typedef enum logic [1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_NAK   = 2'b10,
        HS_STALL = 2'b11
    } hs_code_e;
endpackage

// File: rtl/ep_halt_regs.sv
module ep_halt_regs #(
    parameter int NUM_EP = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              setup_rcvd,
    input  logic              setup_pend,
    output logic [NUM_EP-1:0] stall_q,
    output logic              xcvr_q
);
    typedef struct packed {
        logic [NUM_EP-1:0] stall;
        logic              xcvr;
    } regs_t;

    regs_t st_d, st_q;
    logic  stall_wr, xcvr_wr;

    assign stall_wr = reg_we && !reg_sel;
    assign xcvr_wr  = reg_we && reg_sel;

    always_comb begin
        st_d = st_q;
        if (stall_wr) begin
            st_d.stall = reg_wdata[NUM_EP-1:0];
            // a set of endpoint 0 is blocked while setup is pending
            if (setup_pend && reg_wdata[0])
                st_d.stall[0] = st_q.stall[0];
        end
        if (setup_rcvd)
            st_d.stall[0] = 1'b0;
        if (xcvr_wr)
            st_d.xcvr = reg_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stall_q = st_q.stall;
    assign xcvr_q  = st_q.xcvr;

    AST_EP0_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
        setup_rcvd |=> !stall_q[0]); // R4
    AST_EP0_SET_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_wr && setup_pend && !stall_q[0]) |=> !stall_q[0]); // R5
    AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_wr |=> $stable(stall_q[NUM_EP-1:1])); // R6
endmodule

// File: rtl/ep_halt_resp.sv
module ep_halt_resp
    import ep_halt_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int EPN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  logic [EPN_W-1:0]  tok_ep,
    input  logic [NUM_EP-1:0] ep_ready,
    input  logic [NUM_EP-1:0] stall_q,
    output logic              hs_valid,
    output logic [1:0]        hs_code
);
    localparam int IDX_W = $clog2(NUM_EP);

    typedef struct packed {
        logic     valid;
        hs_code_e code;
    } resp_t;

    resp_t            rs_d, rs_q;
    logic             ep_in_range;
    logic [IDX_W-1:0] ep_idx;

    assign ep_in_range = tok_ep < EPN_W'(NUM_EP);
    assign ep_idx      = tok_ep[IDX_W-1:0];

    always_comb begin
        rs_d = '{valid: 1'b0, code: HS_NONE};
        if (tok_valid && ep_in_range) begin
            rs_d.valid = 1'b1;
            if (stall_q[ep_idx])       rs_d.code = HS_STALL;
            else if (ep_ready[ep_idx]) rs_d.code = HS_ACK;
            else                       rs_d.code = HS_NAK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '{valid: 1'b0, code: HS_NONE};
        else        rs_q <= rs_d;
    end

    assign hs_valid = rs_q.valid;
    assign hs_code  = rs_q.code;

    AST_STALL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && ep_in_range && stall_q[ep_idx]) |=> (hs_code == 2'b11)); // R3
    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && ep_in_range) |=> hs_valid); // R7
    AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_valid |=> (!hs_valid && hs_code == 2'b00)); // R7
    AST_BAD_EP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && !ep_in_range) |=> !hs_valid); // R8
endmodule

// File: rtl/ep_halt_ctrl.sv
module ep_halt_ctrl #(
    parameter int NUM_EP = 4,
    parameter int DATA_W = 8,
    parameter int EPN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              setup_rcvd,
    input  logic              setup_pend,
    input  logic              tok_valid,
    input  logic [EPN_W-1:0]  tok_ep,
    input  logic [NUM_EP-1:0] ep_ready,
    output logic              hs_valid,
    output logic [1:0]        hs_code,
    output logic              ext_xcvr_en
);
    logic [NUM_EP-1:0] stall_q;
    logic              xcvr_q;

    ep_halt_regs #(.NUM_EP(NUM_EP), .DATA_W(DATA_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_sel    (reg_sel),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .setup_rcvd (setup_rcvd),
        .setup_pend (setup_pend),
        .stall_q    (stall_q),
        .xcvr_q     (xcvr_q)
    );

    ep_halt_resp #(.NUM_EP(NUM_EP), .EPN_W(EPN_W)) resp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_valid (tok_valid),
        .tok_ep    (tok_ep),
        .ep_ready  (ep_ready),
        .stall_q   (stall_q),
        .hs_valid  (hs_valid),
        .hs_code   (hs_code)
    );

    always_comb begin
        if (reg_sel) reg_rdata = {{(DATA_W-1){1'b0}}, xcvr_q};
        else         reg_rdata = {{(DATA_W-NUM_EP){1'b0}}, stall_q};
    end

    assign ext_xcvr_en = xcvr_q;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:NUM_EP] == '0); // R2
    AST_XCVR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel) |=> (ext_xcvr_en == $past(reg_wdata[0]))); // R9
endmodule

// File: tb/ep_halt_ctrl_tb.sv
module ep_halt_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0, reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       setup_rcvd = 1'b0, setup_pend = 1'b0;
    logic       tok_valid = 1'b0;
    logic [3:0] tok_ep = '0;
    logic [3:0] ep_ready = '0;
    logic       hs_valid;
    logic [1:0] hs_code;
    logic       ext_xcvr_en;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ep_halt_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .setup_rcvd(setup_rcvd),
        .setup_pend(setup_pend), .tok_valid(tok_valid), .tok_ep(tok_ep),
        .ep_ready(ep_ready), .hs_valid(hs_valid), .hs_code(hs_code),
        .ext_xcvr_en(ext_xcvr_en)
    );

    typedef struct packed {
        logic       sel;
        logic       we;
        logic [7:0] wd;
        logic       srx;
        logic       spend;
        logic       tv;
        logic [3:0] ep;
        logic [3:0] rdy;
        logic       ev;
        logic [1:0] ec;
        logic [7:0] er;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,4'd0, 4'b0001,1'b1,2'b01,8'h00}, // R7 ack
        '{1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,4'd1, 4'b0000,1'b1,2'b10,8'h00}, // R7 nak
        '{1'b0,1'b1,8'h0A,1'b0,1'b0,1'b1,4'd2, 4'b0100,1'b1,2'b01,8'h0A}, // R1 write, R7 pre-write
        '{1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,4'd1, 4'b1111,1'b1,2'b11,8'h0A}, // R3
        '{1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,4'd3, 4'b1111,1'b1,2'b11,8'h0A}, // R3
        '{1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,4'd2, 4'b0000,1'b1,2'b10,8'h0A}, // R7
        '{1'b0,1'b1,8'hF5,1'b0,1'b0,1'b1,4'd5, 4'b1111,1'b0,2'b00,8'h05}, // R2, R8
        '{1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,4'd0, 4'b1111,1'b1,2'b11,8'h05}, // R3
        '{1'b0,1'b0,8'h00,1'b1,1'b0,1'b1,4'd15,4'b1111,1'b0,2'b00,8'h04}, // R4, R6, R8
        '{1'b0,1'b1,8'h01,1'b0,1'b1,1'b1,4'd2, 4'b1111,1'b1,2'b11,8'h00}, // R5
        '{1'b0,1'b1,8'h0F,1'b0,1'b1,1'b1,4'd0, 4'b0001,1'b1,2'b01,8'h0E}, // R5
        '{1'b0,1'b1,8'h01,1'b1,1'b0,1'b1,4'd1, 4'b0000,1'b1,2'b11,8'h00}, // R4 collision
        '{1'b0,1'b1,8'h01,1'b0,1'b0,1'b0,4'd0, 4'b0000,1'b0,2'b00,8'h01}, // R1
        '{1'b0,1'b1,8'h03,1'b0,1'b1,1'b0,4'd0, 4'b0000,1'b0,2'b00,8'h03}, // R5 hold 1
        '{1'b0,1'b1,8'h00,1'b0,1'b1,1'b1,4'd0, 4'b0000,1'b1,2'b11,8'h00}, // R5 clear
        '{1'b1,1'b1,8'hFF,1'b0,1'b0,1'b1,4'd3, 4'b1000,1'b1,2'b01,8'h01}, // R9
        '{1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,4'd0, 4'b0000,1'b0,2'b00,8'h00}  // R1
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
        setup_rcvd = 1'b0; setup_pend = 1'b0; tok_valid = 1'b0;
    endtask

    task automatic reg_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 stall reg", 32'(reg_rdata), 32'h00);
        chk("R10 hs_valid", 32'(hs_valid), 32'h0);
        chk("R10 ext_xcvr_en", 32'(ext_xcvr_en), 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            reg_sel = VECS[i].sel; reg_we = VECS[i].we; reg_wdata = VECS[i].wd;
            setup_rcvd = VECS[i].srx; setup_pend = VECS[i].spend;
            tok_valid = VECS[i].tv; tok_ep = VECS[i].ep; ep_ready = VECS[i].rdy;
            @(posedge clk);
            #1;
            chk($sformatf("R7 vec%0d hs_valid", i), 32'(hs_valid), 32'(VECS[i].ev));
            chk($sformatf("R3/R7 vec%0d hs_code", i), 32'(hs_code), 32'(VECS[i].ec));
            chk($sformatf("R1/R4/R5 vec%0d rdata", i), 32'(reg_rdata), 32'(VECS[i].er));
        end
        @(negedge clk);
        idle_inputs();
        #1;
        chk("R9 ext_xcvr_en set", 32'(ext_xcvr_en), 32'h1);
        chk("R7 strobe single cycle", 32'(hs_valid), 32'h0);

        // R6: endpoint 1 flag survives a setup pulse
        reg_write(1'b0, 8'h02);
        @(negedge clk); setup_rcvd = 1'b1;
        @(negedge clk); setup_rcvd = 1'b0;
        chk("R6 ep1 kept", 32'(reg_rdata), 32'h02);

        // R9: clear transceiver select, readback with bits 7:1 zero
        reg_write(1'b1, 8'hFE);
        reg_sel = 1'b1; #1;
        chk("R9 readback", 32'(reg_rdata), 32'h00);
        chk("R9 ext_xcvr_en clear", 32'(ext_xcvr_en), 32'h0);
        reg_sel = 1'b0;

        // R10: reset in mid-run clears flags
        reg_write(1'b0, 8'h0F);
        reg_write(1'b1, 8'h01);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); #1;
        chk("R10 flags after reset", 32'(reg_rdata), 32'h00);
        chk("R10 xcvr after reset", 32'(ext_xcvr_en), 32'h0);
        rst_n = 1'b1;

        // R8: every out-of-range endpoint is silent
        for (int e = 4; e < 16; e++) begin
            @(negedge clk); tok_valid = 1'b1; tok_ep = 4'(e); ep_ready = 4'hF;
            @(posedge clk); #1;
            chk($sformatf("R8 ep%0d", e), 32'(hs_valid), 32'h0);
        end
        @(negedge clk); idle_inputs();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule